// File: doc/BRIEF.md
# Two-Level Priority Peripheral Interrupt Controller

This block collects sixteen peripheral event lines, organised as two banks of eight, and turns them into interrupt requests for a processor core. Each source has a sticky pending flag, an enable bit and a priority bit. Each of these is held in per-bank registers that software reads and writes through a simple register port. The block drives two request lines: an urgent request and a normal request.

A control register holds one mode bit. While that bit is clear, the block runs in a single-level compatibility mode. Every enabled pending source then raises the urgent request, but only when both the global enable and the peripheral enable inputs are high. The priority bits are ignored in this mode. When the mode bit is set, each enabled pending source is steered by its own priority bit. The urgent request is gated by the global enable, and the normal request is gated by the peripheral enable input, which acts as the low-level global gate.

Pending flags are never cleared by hardware. Software clears a flag after servicing the source, and it clears it before enabling the source as well. Software may also set a flag to force an interrupt.

Top module: `pirq_ctrl`

## Requirements
- R1: A source event sampled high at a clock edge sets that source's pending flag at that edge, whatever the enable, priority, mode or global gate values are. Source i maps to bank i/8, bit i%8.
- R2: Flags are cleared only by a software write. Writing a flag register loads the written value, so a 1 sets a bit and a 0 clears it. Without such a write, no flag bit ever falls.
- R3: When a source event and a software clear hit the same flag bit at the same edge, the flag ends up set.
- R4: After reset, flags read 0x00, enables read 0x00, priorities read 0xFF and the control register reads 0x00, so the block starts in compatibility mode.
- R5: In compatibility mode (control bit 7 = 0), req_hi = (any flag AND enable) AND en_global AND en_periph, req_lo = 0, and the priority bits have no effect.
- R6: In priority mode (control bit 7 = 1), req_hi is high exactly when en_global is 1 and some source has flag, enable and priority all equal to 1.
- R7: In priority mode, req_lo is high exactly when en_periph is 1 and some source has flag = 1, enable = 1 and priority = 0.
- R8: Control register bit 7 is the priority-mode bit. Its other bits read 0 and ignore writes.
- R9: Register addresses are: 0 and 1 for the flags of banks 0 and 1, 2 and 3 for the enables, 4 and 5 for the priorities, and 6 for control. Address 7 reads 0. rdata is the combinational read of addr. Requests are combinational from the stored registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 16 | Peripheral event lines, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| en_global | input | 1 | Global enable; gates the urgent request |
| en_periph | input | 1 | Peripheral enable; gates the normal request in priority mode and all requests in compatibility mode |
| req_hi | output | 1 | Urgent interrupt request |
| req_lo | output | 1 | Normal interrupt request |

## Verification
The bench first applies events with every enable and gate low, which shows that flag capture is independent of gating. It then sweeps the priority bits and both gates in compatibility mode, where the requests must not move. The same patterns are repeated in priority mode to show that sources split by their priority bit and that each gate acts on only one line. Directed cycles then place an event and a software clear on the same bit and write every control bit. A long random run follows that mixes writes, events and gate changes across all addresses, with the outputs compared each cycle against a behavioural model.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int BANK_W   = 8;
  localparam int MODE_BIT = 7;

  typedef logic [BANK_W-1:0] bank_t;

  // Pending-and-enabled sources, optionally filtered by priority class.
  function automatic logic f_bank_hit(input bank_t flag, input bank_t en,
                                      input bank_t prio, input logic sel_hi);
    bank_t cls;
    cls = sel_hi ? prio : ~prio;
    return |(flag & en & cls);
  endfunction

  // Next flag value: software load first, then hardware events dominate.
  function automatic bank_t f_flag_next(input bank_t cur, input logic load,
                                        input bank_t wval, input bank_t evt);
    bank_t base;
    base = load ? wval : cur;
    return base | evt;
  endfunction
endpackage

// File: rtl/pirq_bank.sv
module pirq_bank
  import pirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t evt,
  input  logic  ld_flag,
  input  logic  ld_en,
  input  logic  ld_prio,
  input  bank_t wval,
  output bank_t flag_q,
  output bank_t en_q,
  output bank_t prio_q,
  output logic  hit_any,
  output logic  hit_hi,
  output logic  hit_lo
);
  bank_t flag_d;

  always_comb flag_d = f_flag_next(flag_q, ld_flag, wval, evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      prio_q <= '1;
    end else begin
      flag_q <= flag_d;
      if (ld_en)   en_q   <= wval;
      if (ld_prio) prio_q <= wval;
    end
  end

  always_comb begin
    hit_any = |(flag_q & en_q);
    hit_hi  = f_bank_hit(flag_q, en_q, prio_q, 1'b1);
    hit_lo  = f_bank_hit(flag_q, en_q, prio_q, 1'b0);
  end

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt))); // R1
  AST_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_flag |=> (($past(flag_q) & ~flag_q) == '0)); // R2
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_flag && evt != '0) |=> ((flag_q & $past(evt)) == $past(evt))); // R3
endmodule

// File: rtl/pirq_route.sv
module pirq_route #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_any,
  input  logic [NUM_BANKS-1:0] bank_hi,
  input  logic [NUM_BANKS-1:0] bank_lo,
  input  logic                 prio_mode,
  input  logic                 en_global,
  input  logic                 en_periph,
  output logic                 req_hi,
  output logic                 req_lo
);
  logic compat_req;
  logic split_hi;
  logic split_lo;

  always_comb begin
    compat_req = (|bank_any) & en_global & en_periph;
    split_hi   = (|bank_hi) & en_global;
    split_lo   = (|bank_lo) & en_periph;
    req_hi     = prio_mode ? split_hi : compat_req;
    req_lo     = prio_mode ? split_lo : 1'b0;
  end

  AST_COMPAT_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_mode |-> !req_lo); // R5
  AST_COMPAT_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio_mode && !en_periph) |-> !req_hi); // R5
  AST_HI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_global |-> !req_hi); // R6
  AST_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_periph |-> !req_lo); // R7
  AST_NO_SOURCE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_any == '0) |-> (!req_hi && !req_lo)); // R6
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_evt,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  input  logic                        en_global,
  input  logic                        en_periph,
  output logic                        req_hi,
  output logic                        req_lo
);
  localparam int EN_BASE   = NUM_BANKS;
  localparam int PRIO_BASE = 2 * NUM_BANKS;
  localparam int CTRL_ADDR = 3 * NUM_BANKS;

  bank_t flag_v [NUM_BANKS];
  bank_t en_v   [NUM_BANKS];
  bank_t prio_v [NUM_BANKS];
  logic [NUM_BANKS-1:0] b_any, b_hi, b_lo;
  logic prio_mode;
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_mode <= 1'b0;
    else if (ctrl_wr) prio_mode <= wdata[MODE_BIT];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pirq_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (src_evt[b*BANK_W +: BANK_W]),
      .ld_flag (wr_en && (addr == ADDR_W'(b))),
      .ld_en   (wr_en && (addr == ADDR_W'(EN_BASE + b))),
      .ld_prio (wr_en && (addr == ADDR_W'(PRIO_BASE + b))),
      .wval    (wdata),
      .flag_q  (flag_v[b]),
      .en_q    (en_v[b]),
      .prio_q  (prio_v[b]),
      .hit_any (b_any[b]),
      .hit_hi  (b_hi[b]),
      .hit_lo  (b_lo[b])
    );
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(b))             rdata = flag_v[b];
      if (addr == ADDR_W'(EN_BASE + b))   rdata = en_v[b];
      if (addr == ADDR_W'(PRIO_BASE + b)) rdata = prio_v[b];
    end
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdata           = '0;
      rdata[MODE_BIT] = prio_mode;
    end
  end

  pirq_route #(.NUM_BANKS(NUM_BANKS)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_any  (b_any),
    .bank_hi   (b_hi),
    .bank_lo   (b_lo),
    .prio_mode (prio_mode),
    .en_global (en_global),
    .en_periph (en_periph),
    .req_hi    (req_hi),
    .req_lo    (req_lo)
  );

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CTRL_ADDR)) |-> (rdata[MODE_BIT-1:0] == '0)); // R8
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(prio_mode)); // R8
endmodule

// File: tb/pirq_ctrl_bench.sv
`timescale 1ns/1ps
module pirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        en_global = 1'b0;
  logic        en_periph = 1'b0;
  logic        req_hi, req_lo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_flag [2];
  int m_en   [2];
  int m_pr   [2];
  int m_ctrl;

  always #4 clk = ~clk;

  pirq_ctrl u_pirq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .en_global(en_global), .en_periph(en_periph),
    .req_hi(req_hi), .req_lo(req_lo)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0, 1: return m_flag[a];
      2, 3: return m_en[a-2];
      4, 5: return m_pr[a-4];
      6:    return m_ctrl;
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string tag);
    int any_a = 0, h = 0, l = 0, e_hi, e_lo;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++)
        if (m_flag[b][i] && m_en[b][i]) begin
          any_a = 1;
          if (m_pr[b][i]) h = 1; else l = 1;
        end
    if (m_ctrl[7]) begin
      e_hi = h & int'(en_global);
      e_lo = l & int'(en_periph);
    end else begin
      e_hi = any_a & int'(en_global) & int'(en_periph);
      e_lo = 0;
    end
    check(tag, "req_hi", int'(req_hi), e_hi);
    check(tag, "req_lo", int'(req_lo), e_lo);
    check(tag, "rdata", int'(rdata), model_read(int'(addr)));
  endtask

  task automatic step(input bit we, input int a, input int d, input int ev,
                      input bit eg, input bit ep, input string tag);
    wr_en = we; addr = 3'(a); wdata = 8'(d); src_evt = 16'(ev);
    en_global = eg; en_periph = ep;
    @(posedge clk);
    if (we) begin
      if (a < 2)       m_flag[a]  = d & 8'hFF;
      else if (a < 4)  m_en[a-2]  = d & 8'hFF;
      else if (a < 6)  m_pr[a-4]  = d & 8'hFF;
      else if (a == 6) m_ctrl     = d & 8'h80;
    end
    m_flag[0] |= ev & 8'hFF;
    m_flag[1] |= (ev >> 8) & 8'hFF;
    #2;
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_flag = '{0, 0}; m_en = '{0, 0}; m_pr = '{8'hFF, 8'hFF}; m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset values, R9 unmapped address
    for (int a = 0; a < 8; a++) step(0, a, 0, 0, 0, 0, "R4");
    step(0, 7, 0, 0, 1, 1, "R9");
    // R1 events captured with everything gated off
    step(0, 0, 0, 16'h0081, 0, 0, "R1");
    step(0, 1, 0, 16'h4200, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 1, "R1");
    // R5 compatibility mode: enable sources, sweep gates and priorities
    step(1, 2, 8'h01, 0, 1, 1, "R5");
    step(0, 2, 0, 0, 1, 0, "R5");
    step(0, 2, 0, 0, 0, 1, "R5");
    step(1, 4, 8'h00, 0, 1, 1, "R5");
    step(0, 4, 0, 0, 1, 1, "R5");
    // R8 control register reserved bits
    step(1, 6, 8'h7F, 0, 1, 1, "R8");
    step(1, 6, 8'hFF, 0, 1, 1, "R8");
    // R6 / R7 priority mode routing
    step(0, 6, 0, 0, 1, 1, "R7");
    step(0, 6, 0, 0, 1, 0, "R7");
    step(1, 4, 8'h01, 0, 1, 1, "R6");
    step(0, 4, 0, 0, 0, 1, "R6");
    step(1, 3, 8'h02, 0, 1, 1, "R6");
    step(1, 5, 8'h00, 0, 1, 1, "R7");
    step(0, 5, 0, 0, 0, 1, "R7");
    // R2 software clear and set
    step(1, 1, 8'h00, 0, 1, 1, "R2");
    step(1, 0, 8'h10, 0, 1, 1, "R2");
    step(0, 0, 0, 0, 1, 1, "R2");
    // R3 event and clear on the same bit
    step(1, 0, 8'h00, 16'h0010, 1, 1, "R3");
    step(0, 0, 0, 0, 1, 1, "R3");
    // mixed random run across all requirements
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom;
      step(r[0] & r[1], int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
           (r[4:2] == 0) ? int'($urandom_range(0, 65535)) : 0,
           r[5] | r[6], r[7] | r[8], "R9");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule